// File: doc/BRIEF.md
# Port-Selectable Edge Interrupt Detector

This block turns GPIO pin activity into eight sticky interrupt requests. Each interrupt index x has its own two-way source mux: it follows either pin x of input port A or pin x of input port B. It also has its own polarity choice, so the request fires on either the rising or the falling transition of that pin. The chosen pin goes through a two-flop synchroniser. It is then compared with its previous synchronised value in the system clock domain. A qualifying transition latches a pending flag, which stays set until software clears it.

A small register bus gives access to three locations in a 12-bit register page. Polarity selection is at 0xFCD and source selection at 0xFCE. Both are read/write. The pending flags are at 0xFCF: a read returns them, and writing a 1 to a bit clears it. The block drives the pending flags out as an 8-bit vector, together with a single combined request line.

Each lane runs a two-state controller. **ST_FLUSH** discards comparisons while the synchroniser refills. **ST_WATCH** qualifies transitions. The transitions are:
- *reset → ST_FLUSH*, with the flush counter loaded.
- *ST_FLUSH → ST_FLUSH*: the counter counts down, and any new configuration change reloads it.
- *ST_FLUSH → ST_WATCH*: taken when the counter reaches zero.
- *ST_WATCH → ST_FLUSH*: taken when the lane's source or polarity bit changes.

A reconfiguration therefore never produces a false edge.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the polarity register, the source register and the pending flags read 0x00, and `irq` is low.
- R2: Writes to 0xFCD (polarity) and 0xFCE (source) are stored and read back unchanged. Bit x of each register belongs to index x. A read of any address outside 0xFCD..0xFCF returns 0x00.
- R3: Source bit x = 0 makes interrupt x follow `port_a[x]`, and 1 makes it follow `port_b[x]`. Transitions on the pin that is not selected have no effect on pending bit x.
- R4: Polarity bit x = 1 sets pending bit x on a 0→1 transition of the selected pin, and 0 sets it on a 1→0 transition. The opposite transition sets nothing.
- R5: After a qualifying pin change, pending bit x is still 0 following the second rising clock edge. It is 1 following the third.
- R6: A pulse that lasts two clock periods on the selected pin is always latched.
- R7: Writing a 1 to bit x of 0xFCF clears pending bit x. Bits written as 0 keep their value.
- R8: When a new qualifying edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R9: Changing a lane's source or polarity bit never raises that lane's request, even when the newly selected pin sits at a different level. A real edge after the change is still detected.
- R10: `irq_vec` bit x equals pending bit x, and `irq` is high exactly when any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a | input | 8 | First candidate pin port (asynchronous) |
| port_b | input | 8 | Second candidate pin port (asynchronous) |
| bus_addr | input | 12 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_vec | output | 8 | Pending flags, one per index |
| irq | output | 1 | OR of all pending flags |

## Verification
The assertions take two things for granted.
- Bus writes are single-cycle strobes with stable address and data at the sampling edge.
- Pin levels seen by a lane are only meaningful once they have been held for at least one full clock period.

The stimulus keeps to both. It changes pins and bus signals only on the falling clock edge, and it holds every pin level for at least two periods. Source and polarity bits are changed only while the pins are steady, except in the deliberate reconfiguration test. There, the newly selected pin is held at a different level so that the flush path is exercised.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_WATCH = 1'b1
    } lane_state_e;

    localparam int unsigned DEF_LANES   = 8;
    localparam int unsigned DEF_ADDR_W  = 12;
    localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned            LANES     = 8,
    parameter int unsigned            ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]      ADDR_POL  = 12'hFCD,
    parameter logic [ADDR_W-1:0]      ADDR_SRC  = 12'hFCE,
    parameter logic [ADDR_W-1:0]      ADDR_PEND = 12'hFCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LANES-1:0]  bus_wdata,
    input  logic [LANES-1:0]  pend_in,
    output logic [LANES-1:0]  pol_rise,
    output logic [LANES-1:0]  src_sel,
    output logic [LANES-1:0]  pend_clr,
    output logic [LANES-1:0]  bus_rdata
);
    logic hit_pol, hit_src, hit_pend;

    assign hit_pol  = (bus_addr == ADDR_POL);
    assign hit_src  = (bus_addr == ADDR_SRC);
    assign hit_pend = (bus_addr == ADDR_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_rise <= '0;
            src_sel  <= '0;
        end else if (bus_we) begin
            if (hit_pol) pol_rise <= bus_wdata;
            if (hit_src) src_sel  <= bus_wdata;
        end
    end

    always_comb begin
        pend_clr = (bus_we && hit_pend) ? bus_wdata : '0;
        unique case (1'b1)
            hit_pol:  bus_rdata = pol_rise;
            hit_src:  bus_rdata = src_sel;
            hit_pend: bus_rdata = pend_in;
            default:  bus_rdata = '0;
        endcase
    end

    assert_pol_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_pol) |=> (pol_rise == $past(bus_wdata)));
    assert_src_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_src) |=> (src_sel == $past(bus_wdata)));
endmodule

// File: rtl/irq_lane.sv
module irq_lane
    import edge_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic src_sel,
    input  logic pol_rise,
    input  logic clr,
    output logic det,
    output logic pend
);
    localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 2);
    localparam logic [CNT_W-1:0] FLUSH_LEN = CNT_W'(SYNC_STAGES);

    lane_state_e            state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [1:0]             cfg_q;
    logic                   raw, smp, chg;

    assign raw = src_sel ? pin_b : pin_a;
    assign smp = sync_q[SYNC_STAGES-1];
    assign chg = (cfg_q != {src_sel, pol_rise});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            cfg_q  <= 2'b00;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            prev_q <= smp;
            cfg_q  <= {src_sel, pol_rise};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
            cnt_q   <= FLUSH_LEN;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        det     = 1'b0;
        unique case (state_q)
            ST_FLUSH: begin
                if (chg) begin
                    cnt_d = FLUSH_LEN;
                end else if (cnt_q == '0) begin
                    state_d = ST_WATCH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WATCH: begin
                if (chg) begin
                    state_d = ST_FLUSH;
                    cnt_d   = FLUSH_LEN;
                end else begin
                    det = pol_rise ? (smp && !prev_q) : (!smp && prev_q);
                end
            end
            default: begin
                state_d = ST_FLUSH;
                cnt_d   = FLUSH_LEN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !clr) || det;
    end

    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> pend);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (det && clr) |=> pend);
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !det) |=> !pend);
    assert_rise_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(det));
    assert_reconfig_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !det);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import edge_irq_pkg::*;
#(
    parameter int unsigned       LANES       = DEF_LANES,
    parameter int unsigned       ADDR_W      = DEF_ADDR_W,
    parameter int unsigned       SYNC_STAGES = DEF_SYNC,
    parameter logic [ADDR_W-1:0] ADDR_POL    = 12'hFCD,
    parameter logic [ADDR_W-1:0] ADDR_SRC    = 12'hFCE,
    parameter logic [ADDR_W-1:0] ADDR_PEND   = 12'hFCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  port_a,
    input  logic [LANES-1:0]  port_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LANES-1:0]  bus_wdata,
    output logic [LANES-1:0]  bus_rdata,
    output logic [LANES-1:0]  irq_vec,
    output logic              irq
);
    logic [LANES-1:0] pol_rise, src_sel, pend_clr, lane_det, lane_pend;

    irq_cfg_regs #(
        .LANES(LANES), .ADDR_W(ADDR_W),
        .ADDR_POL(ADDR_POL), .ADDR_SRC(ADDR_SRC), .ADDR_PEND(ADDR_PEND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .pend_in(lane_pend),
        .pol_rise(pol_rise), .src_sel(src_sel), .pend_clr(pend_clr),
        .bus_rdata(bus_rdata)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        irq_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .pin_a(port_a[gi]), .pin_b(port_b[gi]),
            .src_sel(src_sel[gi]), .pol_rise(pol_rise[gi]),
            .clr(pend_clr[gi]),
            .det(lane_det[gi]), .pend(lane_pend[gi])
        );
    end

    assign irq_vec = lane_pend;
    assign irq     = |lane_pend;

    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|lane_det));
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_a = '0, port_b = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, irq_vec;
    logic        irq;
    int          checks = 0, failures = 0;

    localparam logic [11:0] A_POL = 12'hFCD, A_SRC = 12'hFCE, A_PEND = 12'hFCF;

    gpio_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_vec(irq_vec), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_pin(input bit use_b, input int i, input logic v);
        if (use_b) port_b[i] = v; else port_a[i] = v;
    endtask

    initial begin
        logic [7:0] d;
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(A_POL, d);  chk("R1 pol reset", d, 8'h00);
        rd(A_SRC, d);  chk("R1 src reset", d, 8'h00);
        rd(A_PEND, d); chk("R1 pend reset", d, 8'h00);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);

        // R2 register access
        wr(A_POL, 8'hA5); wr(A_SRC, 8'h3C);
        rd(A_POL, d); chk("R2 pol readback", d, 8'hA5);
        rd(A_SRC, d); chk("R2 src readback", d, 8'h3C);
        rd(12'h000, d); chk("R2 unmapped", d, 8'h00);
        rd(12'hFCC, d); chk("R2 unmapped", d, 8'h00);

        // R3/R4/R5/R7 exhaustive over index, source, polarity
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 2; e++) begin
                    logic idl;
                    idl = (e == 0);
                    @(negedge clk);
                    port_a = '0; port_b = '0;
                    set_pin(s[0], i, idl);
                    wr(A_POL, 8'(e) << i);
                    wr(A_SRC, 8'(s) << i);
                    idle(8);
                    wr(A_PEND, 8'hFF);
                    chk("R7 clear all", irq_vec, 8'h00);
                    // unselected pin toggles both ways
                    set_pin(!s[0], i, 1'b1); idle(3);
                    set_pin(!s[0], i, 1'b0); idle(3);
                    set_pin(!s[0], i, 1'b1); idle(6);
                    chk("R3 unselected ignored", irq_vec, 8'h00);
                    // qualifying edge with latency check
                    set_pin(s[0], i, !idl);
                    @(posedge clk); @(posedge clk); @(negedge clk);
                    chk("R5 not before third edge", irq_vec, 8'h00);
                    @(negedge clk);
                    chk("R4 R5 edge latched", irq_vec, 8'h01 << i);
                    chk("R10 irq high", {7'b0, irq}, 8'h01);
                    wr(A_PEND, ~(8'h01 << i));
                    chk("R7 zero bits keep", irq_vec, 8'h01 << i);
                    wr(A_PEND, 8'h01 << i);
                    chk("R7 w1c", irq_vec, 8'h00);
                    chk("R10 irq low", {7'b0, irq}, 8'h00);
                    // opposite edge
                    set_pin(s[0], i, idl); idle(6);
                    chk("R4 opposite edge ignored", irq_vec, 8'h00);
                    port_b[i] = 1'b0; port_a[i] = 1'b0;
                end
            end
        end

        // R6 two-cycle pulse, rising on port A lane 3
        @(negedge clk); port_a = '0; port_b = '0;
        wr(A_POL, 8'hFF); wr(A_SRC, 8'h00); idle(8); wr(A_PEND, 8'hFF);
        @(negedge clk); port_a[3] = 1'b1; idle(2); port_a[3] = 1'b0; idle(6);
        chk("R6 short pulse latched", irq_vec, 8'h08);
        wr(A_PEND, 8'hFF);

        // R8 set wins over clear in the same cycle
        @(negedge clk); port_a[5] = 1'b1; idle(6);
        chk("R8 pre-set", irq_vec, 8'h20);
        port_a[5] = 1'b0; idle(6);
        port_a[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(A_PEND, 8'h20);
        chk("R8 set wins", irq_vec, 8'h20);
        wr(A_PEND, 8'h20);
        chk("R8 later clear", irq_vec, 8'h00);

        // R9 reconfiguration raises nothing
        @(negedge clk); port_a = 8'h00; port_b = 8'hFF;
        wr(A_POL, 8'hFF); wr(A_SRC, 8'h00); idle(8); wr(A_PEND, 8'hFF);
        wr(A_SRC, 8'hFF); idle(10);
        chk("R9 source switch quiet", irq_vec, 8'h00);
        wr(A_POL, 8'h00); idle(10);
        chk("R9 polarity switch quiet", irq_vec, 8'h00);
        port_b = 8'h00; idle(6);
        chk("R9 real edge after switch", irq_vec, 8'hFF);
        rd(A_PEND, d); chk("R10 pend read matches", d, 8'hFF);
        chk("R10 irq any", {7'b0, irq}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule